// File: doc/BRIEF.md
# Rectangular Window Fill Engine

This block fills a rectangular region of a byte-wide display memory with one stored byte value. Software programs a pattern byte and four bound registers (left column, top row, right column, bottom row). It then sets the start bit in the control register. From the next clock on, the engine issues one write per cycle on a simple synchronous memory write port. It covers every location of the window, corners included, until the whole area holds the pattern.

Locations are visited row by row from top to bottom, and left to right inside each row. The address of a location is its row times a fixed line stride plus its column. The start bit doubles as a busy flag that software can poll. It drops by itself at the clock edge that completes the last write. The other control bits are ordinary storage and are not disturbed by that automatic clearing. While a fill runs, the pattern and bound registers are frozen, so the fill always uses the values present when it started.

Top module: `win_fill`

## Requirements
- R1: After reset every register (offsets 0 to 5) reads 00h and `mem_we` is low.
- R2: Register offsets are control = 0, pattern = 1, left = 2, top = 3, right = 4, bottom = 5. While no fill runs, a write to offsets 1 to 5 is read back unchanged. Offsets 6 and 7 read 00h and ignore writes.
- R3: A write to offset 0 with bit 3 set, made while no fill runs, starts a fill. Bit 3 of offset 0 reads 1 from the following cycle.
- R4: Writing 0 to bit 3 of offset 0 neither starts a fill nor stops a running one.
- R5: A fill writes every location with row in [top, bottom] and column in [left, right]. It makes exactly one write per cycle, in row-major order, at address row*LINE_STRIDE + column, and the data is the pattern register value.
- R6: Bit 3 stays 1 for exactly (right-left+1)*(bottom-top+1) cycles after the start edge. It reads 0 in the cycle after the last write.
- R7: If right < left or bottom < top, the fill makes no write. Bit 3 reads 1 for exactly one cycle.
- R8: Writes to offsets 1 to 5 while a fill runs are ignored. Both the readback and the fill data show the values held at start.
- R9: Control bits other than bit 3 keep their value through the automatic clearing. They take the written value on any control write. This includes a write made in the same cycle as the clearing, after which bit 3 reads 0.
- R10: `mem_we` is low whenever no fill is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the register at `reg_addr` |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data (the pattern) |

## Verification
The automatic clearing of the start bit and a software write to the control register can land on the same clock edge. Both change the control register, and the written bits must survive while the start bit still falls. The bench provokes this by counting cycles from the start edge and timing a control write onto the edge that completes the final memory write. A second case places a write one cycle earlier. A behavioural model compares the readback and every memory write each cycle, and a directed readback then confirms the written bits with bit 3 clear.

// File: rtl/win_fill_pkg.sv
package win_fill_pkg;
    localparam int BYTE_W    = 8;
    localparam int REG_AW    = 3;
    localparam int START_BIT = 3;

    localparam logic [REG_AW-1:0] OFS_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] OFS_PAT    = 3'd1;
    localparam logic [REG_AW-1:0] OFS_LEFT   = 3'd2;
    localparam logic [REG_AW-1:0] OFS_TOP    = 3'd3;
    localparam logic [REG_AW-1:0] OFS_RIGHT  = 3'd4;
    localparam logic [REG_AW-1:0] OFS_BOTTOM = 3'd5;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t ctrl;
        byte_t pattern;
        byte_t left;
        byte_t top;
        byte_t right;
        byte_t bottom;
    } regs_t;

    typedef struct packed {
        logic  busy;
        logic  empty;
        byte_t row;
        byte_t col;
    } seq_t;
endpackage

// File: rtl/win_fill_regs.sv
module win_fill_regs
    import win_fill_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  byte_t             reg_wdata,
    input  logic              fill_busy,
    input  logic              fill_done,
    output regs_t             regs,
    output logic              start_pulse,
    output byte_t             reg_rdata
);
    regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        start_pulse = 1'b0;
        if (fill_done) begin
            r_d.ctrl[START_BIT] = 1'b0;
        end
        if (reg_we) begin
            case (reg_addr)
                OFS_CTRL: begin
                    r_d.ctrl = reg_wdata;
                    if (fill_busy) begin
                        // running fill: bit follows only the automatic clear
                        r_d.ctrl[START_BIT] = ~fill_done;
                    end else begin
                        start_pulse = reg_wdata[START_BIT];
                    end
                end
                OFS_PAT:    if (!fill_busy) r_d.pattern = reg_wdata;
                OFS_LEFT:   if (!fill_busy) r_d.left    = reg_wdata;
                OFS_TOP:    if (!fill_busy) r_d.top     = reg_wdata;
                OFS_RIGHT:  if (!fill_busy) r_d.right   = reg_wdata;
                OFS_BOTTOM: if (!fill_busy) r_d.bottom  = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_CTRL:   reg_rdata = r_q.ctrl;
            OFS_PAT:    reg_rdata = r_q.pattern;
            OFS_LEFT:   reg_rdata = r_q.left;
            OFS_TOP:    reg_rdata = r_q.top;
            OFS_RIGHT:  reg_rdata = r_q.right;
            OFS_BOTTOM: reg_rdata = r_q.bottom;
            default:    reg_rdata = '0;
        endcase
    end

    assign regs = r_q;
endmodule

// File: rtl/win_fill_seq.sv
module win_fill_seq
    import win_fill_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_pulse,
    input  byte_t left,
    input  byte_t top,
    input  byte_t right,
    input  byte_t bottom,
    output logic  busy,
    output logic  fill_done,
    output logic  mem_we,
    output byte_t row,
    output byte_t col
);
    seq_t s_d, s_q;
    logic last_col, last_row;

    always_comb begin
        s_d       = s_q;
        fill_done = 1'b0;
        last_col  = (s_q.col == right);
        last_row  = (s_q.row == bottom);
        if (s_q.busy) begin
            if (s_q.empty || (last_col && last_row)) begin
                s_d.busy  = 1'b0;
                s_d.empty = 1'b0;
                fill_done = 1'b1;
            end else if (last_col) begin
                s_d.row = s_q.row + byte_t'(1);
                s_d.col = left;
            end else begin
                s_d.col = s_q.col + byte_t'(1);
            end
        end else if (start_pulse) begin
            s_d.busy  = 1'b1;
            s_d.row   = top;
            s_d.col   = left;
            s_d.empty = (right < left) || (bottom < top);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = s_q.busy;
    assign mem_we = s_q.busy & ~s_q.empty;
    assign row    = s_q.row;
    assign col    = s_q.col;
endmodule

// File: rtl/win_fill_addr.sv
module win_fill_addr
    import win_fill_pkg::*;
#(
    parameter int LINE_STRIDE = 40,
    parameter int ADDR_W      = 16
) (
    input  byte_t              row,
    input  byte_t              col,
    output logic [ADDR_W-1:0]  addr
);
    localparam bit IS_POW2 = ((LINE_STRIDE & (LINE_STRIDE - 1)) == 0);
    localparam int SHIFT   = $clog2(LINE_STRIDE);

    generate
        if (IS_POW2) begin : g_shift
            assign addr = (ADDR_W'(row) << SHIFT) + ADDR_W'(col);
        end else begin : g_mult
            assign addr = ADDR_W'(row) * ADDR_W'(LINE_STRIDE) + ADDR_W'(col);
        end
    endgenerate
endmodule

// File: rtl/win_fill.sv
module win_fill
    import win_fill_pkg::*;
#(
    parameter int LINE_STRIDE = 40,
    parameter int ADDR_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    regs_t regs;
    logic  start_pulse;
    logic  seq_busy;
    logic  fill_done;
    byte_t cur_row, cur_col;

    win_fill_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .fill_busy   (seq_busy),
        .fill_done   (fill_done),
        .regs        (regs),
        .start_pulse (start_pulse),
        .reg_rdata   (reg_rdata)
    );

    win_fill_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_pulse (start_pulse),
        .left        (regs.left),
        .top         (regs.top),
        .right       (regs.right),
        .bottom      (regs.bottom),
        .busy        (seq_busy),
        .fill_done   (fill_done),
        .mem_we      (mem_we),
        .row         (cur_row),
        .col         (cur_col)
    );

    win_fill_addr #(
        .LINE_STRIDE (LINE_STRIDE),
        .ADDR_W      (ADDR_W)
    ) u_addr (
        .row  (cur_row),
        .col  (cur_col),
        .addr (mem_addr)
    );

    assign mem_wdata = regs.pattern;
endmodule

// File: rtl/win_fill_chk.sv
module win_fill_chk
    import win_fill_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic              wdata_start,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input regs_t             regs,
    input logic              busy,
    input byte_t             col
);
    localparam byte_t KEEP_MASK = ~(byte_t'(1) << START_BIT);

    logic ctrl_wr;
    assign ctrl_wr = reg_we && (reg_addr == OFS_CTRL);

    // R10
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> regs.ctrl[START_BIT]);

    // R6
    busy_flag_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == regs.ctrl[START_BIT]);

    // R7
    empty_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_we) |=> !busy);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && (col != regs.left)) |->
            (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R8
    frozen_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            ($stable(regs.pattern) && $stable(regs.left) && $stable(regs.top) &&
             $stable(regs.right) && $stable(regs.bottom)));

    // R9
    keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !busy && !$past(ctrl_wr)) |->
            ((regs.ctrl & KEEP_MASK) == ($past(regs.ctrl) & KEEP_MASK)));

    // R3
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata_start && !busy) |=> busy);

    // R4
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wdata_start && !busy) |=> !busy);
endmodule

bind win_fill win_fill_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .wdata_start (reg_wdata[win_fill_pkg::START_BIT]),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .regs        (regs),
    .busy        (seq_busy),
    .col         (cur_col)
);

// File: tb/win_fill_tb.sv
`timescale 1ns/1ps
module win_fill_tb_top;
    localparam int STRIDE = 40;
    localparam int AW     = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [7:0]    reg_wdata = 8'd0;
    logic [7:0]    reg_rdata;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;

    int  checks = 0;
    int  fails = 0;
    int  wr_count = 0;
    bit  finished = 1'b0;

    int  m_reg[6];
    int  m_q[$];
    bit  m_empty_pend;

    always #5 clk = ~clk;

    win_fill #(.LINE_STRIDE(STRIDE), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        bit busy_pre, done, start;
        if (!rst_n) begin
            foreach (m_reg[i]) m_reg[i] = 0;
            m_q.delete();
            m_empty_pend = 1'b0;
        end else begin
            busy_pre = m_reg[0][3];
            done = 1'b0;
            start = 1'b0;
            if (m_empty_pend) begin
                m_empty_pend = 1'b0;
                done = 1'b1;
            end else if (m_q.size() > 0) begin
                void'(m_q.pop_front());
                if (m_q.size() == 0) done = 1'b1;
            end
            if (done) m_reg[0][3] = 1'b0;
            if (reg_we) begin
                if (reg_addr == 3'd0) begin
                    if (busy_pre) m_reg[0] = {24'd0, reg_wdata[7:4], m_reg[0][3], reg_wdata[2:0]};
                    else begin
                        m_reg[0] = {24'd0, reg_wdata};
                        start = reg_wdata[3];
                    end
                end else if (reg_addr < 3'd6 && !busy_pre) begin
                    m_reg[reg_addr] = {24'd0, reg_wdata};
                end
            end
            if (start) begin
                if (m_reg[4] < m_reg[2] || m_reg[5] < m_reg[3]) m_empty_pend = 1'b1;
                else
                    for (int r = m_reg[3]; r <= m_reg[5]; r++)
                        for (int c = m_reg[2]; c <= m_reg[4]; c++)
                            m_q.push_back(r * STRIDE + c);
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            if (m_q.size() > 0) begin
                chk("R5 mem_we", int'(mem_we), 1);
                chk("R5 mem_addr", int'(mem_addr), m_q[0]);
                chk("R5 mem_wdata", int'(mem_wdata), m_reg[1]);
            end else begin
                chk("R10 mem_we idle", int'(mem_we), 0);
            end
            chk("R2 reg_rdata", int'(reg_rdata), (reg_addr < 3'd6) ? m_reg[reg_addr] : 0);
            if (mem_we) wr_count++;
        end
    end

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output int d);
        reg_addr = a;
        #2;
        d = int'(reg_rdata);
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        reg_addr = 3'd0;
        #2;
        while (reg_rdata[3]) begin
            cyc++;
            @(negedge clk);
            #2;
        end
    endtask

    task automatic set_win(int p, int l, int t, int r, int b);
        wr(3'd1, 8'(p)); wr(3'd2, 8'(l)); wr(3'd3, 8'(t));
        wr(3'd4, 8'(r)); wr(3'd5, 8'(b));
    endtask

    task automatic run_fill(string tag, int ctrl, int exp_cyc, int exp_wr);
        int cyc;
        wr_count = 0;
        wr(3'd0, 8'(ctrl | 8'h08));
        wait_idle(cyc);
        chk({tag, " busy cycles (R6)"}, cyc, exp_cyc);
        chk({tag, " write count (R5)"}, wr_count, exp_wr);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog actual=hung expected=idle");
            finish_run();
        end
    end

    initial begin
        int v, cyc;
        repeat (3) @(negedge clk);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 reset register", v, 0);
        end
        chk("R1 reset mem_we", int'(mem_we), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: readback of pattern and bounds, unused offsets
        set_win(8'h5A, 2, 1, 5, 3);
        rd(3'd1, v); chk("R2 pattern", v, 8'h5A);
        rd(3'd2, v); chk("R2 left", v, 2);
        rd(3'd3, v); chk("R2 top", v, 1);
        rd(3'd4, v); chk("R2 right", v, 5);
        rd(3'd5, v); chk("R2 bottom", v, 3);
        wr(3'd6, 8'hFF);
        rd(3'd6, v); chk("R2 offset 6", v, 0);

        // R3, R5, R6, R9: basic 4x3 fill
        wr_count = 0;
        wr(3'd0, 8'h49);
        rd(3'd0, v); chk("R3 start bit set", v, 8'h49);
        wait_idle(cyc);
        chk("R6 busy cycles 4x3", cyc, 12);
        chk("R5 writes 4x3", wr_count, 12);
        rd(3'd0, v); chk("R9 other bits kept", v, 8'h41);

        // R8: register writes during a fill are ignored
        set_win(8'h77, 0, 4, 3, 7);
        wr_count = 0;
        wr(3'd0, 8'h08);
        wr(3'd1, 8'hC3);
        wr(3'd2, 8'h01);
        wr(3'd5, 8'h09);
        wait_idle(cyc);
        chk("R8 writes use latched window", wr_count, 16);
        rd(3'd1, v); chk("R8 pattern unchanged", v, 8'h77);
        rd(3'd2, v); chk("R8 left unchanged", v, 0);
        rd(3'd5, v); chk("R8 bottom unchanged", v, 7);

        // R4: writing 0 to the start bit
        wr_count = 0;
        wr(3'd0, 8'h30);
        repeat (3) @(negedge clk);
        chk("R4 no start", wr_count, 0);
        rd(3'd0, v); chk("R4 control value", v, 8'h30);
        set_win(8'h11, 1, 1, 2, 2);
        wr_count = 0;
        wr(3'd0, 8'h08);
        wr(3'd0, 8'h00);
        wait_idle(cyc);
        chk("R4 no abort", wr_count, 4);

        // R7: empty windows
        set_win(8'h22, 5, 1, 2, 3);
        run_fill("R7 right<left", 0, 1, 0);
        set_win(8'h22, 1, 4, 3, 1);
        run_fill("R7 bottom<top", 0, 1, 0);

        // R5: single location and a full-row span
        set_win(8'hE7, 7, 9, 7, 9);
        run_fill("R5 single cell", 0, 1, 1);
        set_win(8'h3C, 0, 2, STRIDE - 1, 3);
        run_fill("R5 full rows", 0, 2 * STRIDE, 2 * STRIDE);

        // R9: control write on the clearing edge (3x2 window, 6 writes)
        set_win(8'h99, 10, 0, 12, 1);
        wr_count = 0;
        wr(3'd0, 8'h08);
        repeat (4) @(negedge clk);
        wr(3'd0, 8'h82);
        rd(3'd0, v); chk("R9 same-cycle write and clear", v, 8'h82);
        chk("R9 same-cycle write count", wr_count, 6);

        // R9: control write one cycle before the clearing edge
        wr_count = 0;
        wr(3'd0, 8'h08);
        repeat (3) @(negedge clk);
        wr(3'd0, 8'h24);
        wait_idle(cyc);
        rd(3'd0, v); chk("R9 write before clear", v, 8'h24);
        chk("R9 write before clear count", wr_count, 6);

        repeat (5) @(negedge clk);
        chk("R10 idle mem_we", int'(mem_we), 0);
        finish_run();
    end
endmodule